// File: doc/BRIEF.md
# Receive Link Monitor with Latching Status Bits

This block decides whether a receive link is usable. It watches two inputs: a signal-detect indication from the line side and a lock indication from the receive clock recovery loop. Both inputs are asynchronous to the block clock, so each passes through a two-flop synchronizer first. The block raises a receive channel error whenever either condition is missing. That error is also a link fault, and it takes the link down at once.

The link comes back up only after both conditions have held without a break for a parameterised number of cycles. Link state is shown in two readable bits that follow different latching rules:

- The quick-poll bit shows the live state and does not latch.
- The standard-register bit is latching low. A fault clears it, and it stays clear until it is read while the link is good.

A third bit, the lock-error flag, is latching high. It records any loss of lock until a quick-poll read occurs at a time when lock is present again. The management bus is not part of this block: each register read appears as a one-cycle strobe input.

Top module: `link_watch`

## Requirements
- R1: `sig_det_in` and `pll_lock_in` each pass through two flops. A change driven between clock edges shows up on `rx_chan_err_o` after the second rising edge, not after the first.
- R2: `rx_chan_err_o` is high whenever the synchronized signal-detect is low or the synchronized lock is low. A loss of signal detect alone does not set `lock_err_o`.
- R3: `lock_err_o` goes high one edge after the synchronized lock is seen low. It stays high after lock returns.
- R4: A cycle with `rd_qp_stb` high clears `lock_err_o` at that edge only if the synchronized lock is high. If lock is absent during the read, the flag stays set.
- R5: `link_fault_o` is the inverse of the internal link state. The link rises once both synchronized inputs have been good on GOOD_CYCLES consecutive edges. The link drops on the edge after a channel error is seen.
- R6: Any channel error during the qualifying count restarts the count from zero.
- R7: `qp_link_o` equals the current link state with no latching.
- R8: `std_link_o` is latching low:
  - A channel error or a down link clears it.
  - A cycle with `rd_std_stb` high while the link is up and no channel error is present sets it.
  - A read strobe on the same edge as a fault leaves it at 0.
- R9: After reset, `std_link_o`, `qp_link_o` and `lock_err_o` are 0, and `rx_chan_err_o` and `link_fault_o` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sig_det_in | input | 1 | Receive signal present (asynchronous) |
| pll_lock_in | input | 1 | Receive clock recovery locked (asynchronous) |
| rd_std_stb | input | 1 | One-cycle strobe: standard status register is read |
| rd_qp_stb | input | 1 | One-cycle strobe: quick-poll status register is read |
| std_link_o | output | 1 | Latching-low link status bit |
| qp_link_o | output | 1 | Live link status bit |
| lock_err_o | output | 1 | Latching-high lock-error bit |
| rx_chan_err_o | output | 1 | Receive channel error |
| link_fault_o | output | 1 | Link fault, high while the link is down |

## Verification
A read can land in the same cycle as the event it is meant to clear. The bench provokes this twice:

- It holds the quick-poll read strobe high across the edge where lock is lost. It then expects the lock-error flag to be set on that edge and to stay set while lock is absent.
- It raises the standard-register read strobe on the exact edge where the channel error takes the link down. It then expects the standard link bit to fall to 0, not stay at 1.

It also breaks signal detect for one cycle in the middle of the qualifying count. It then checks that the link is still down at the edge where an unbroken count would already have raised it.

// File: rtl/link_watch.sv
module link_watch #(
  parameter int GOOD_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_det_in,
  input  logic pll_lock_in,
  input  logic rd_std_stb,
  input  logic rd_qp_stb,
  output logic std_link_o,
  output logic qp_link_o,
  output logic lock_err_o,
  output logic rx_chan_err_o,
  output logic link_fault_o
);
  localparam int CW = $clog2(GOOD_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(GOOD_CYCLES - 1);

  logic [1:0]    sd_q, lk_q;
  logic          sd_s, lk_s;
  logic [CW-1:0] cnt;
  logic          link_up, good, std_r, lock_r;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sd_q <= '0;
      lk_q <= '0;
    end else begin
      sd_q <= {sd_q[0], sig_det_in};
      lk_q <= {lk_q[0], pll_lock_in};
    end

  assign sd_s          = sd_q[1];
  assign lk_s          = lk_q[1];
  assign rx_chan_err_o = !sd_s || !lk_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt     <= '0;
      link_up <= 1'b0;
    end else if (rx_chan_err_o) begin
      cnt     <= '0;
      link_up <= 1'b0;
    end else if (!link_up) begin
      if (cnt == LAST) link_up <= 1'b1;
      else             cnt     <= cnt + 1'b1;
    end

  assign good         = link_up && !rx_chan_err_o;
  assign qp_link_o    = link_up;
  assign link_fault_o = !link_up;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          std_r <= 1'b0;
    else if (!good)      std_r <= 1'b0;
    else if (rd_std_stb) std_r <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lock_r <= 1'b0;
    else        lock_r <= !lk_s || (lock_r && !rd_qp_stb);

  assign std_link_o = std_r;
  assign lock_err_o = lock_r;

  p_lock_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_s |=> lock_err_o);
  p_lock_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_err_o && !rd_qp_stb) |=> lock_err_o);
  p_chan_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_chan_err_o |=> link_fault_o);
  p_rise_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qp_link_o) |-> $past(!rx_chan_err_o));
  p_std_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_chan_err_o |=> !std_link_o);
  p_std_noread_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!std_link_o && !rd_std_stb) |=> !std_link_o);
  p_qp_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
    qp_link_o |-> !link_fault_o);
endmodule

// File: tb/sim_link_watch.sv
module sim_link_watch;
  localparam int G = 4;
  logic clk = 0, rst_n = 0;
  logic sd = 0, lk = 0, rd_std = 0, rd_qp = 0;
  logic std_l, qp_l, lerr, cerr, flt;
  int total = 0, bad = 0;
  bit done = 0;

  typedef struct { string tag; logic [4:0] exp; logic [4:0] mask; } item_t;
  item_t q[$];

  always #2 clk = ~clk;

  link_watch #(.GOOD_CYCLES(G)) u0 (
    .clk(clk), .rst_n(rst_n), .sig_det_in(sd), .pll_lock_in(lk),
    .rd_std_stb(rd_std), .rd_qp_stb(rd_qp), .std_link_o(std_l),
    .qp_link_o(qp_l), .lock_err_o(lerr), .rx_chan_err_o(cerr),
    .link_fault_o(flt));

  // bit order {std, qp, lockerr, chanerr, fault}
  task automatic chk(string tag, logic [4:0] exp, logic [4:0] mask);
    item_t it;
    it.tag = tag; it.exp = exp; it.mask = mask;
    q.push_back(it);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [4:0] act;
      it = q.pop_front();
      act = {std_l, qp_l, lerr, cerr, flt};
      total++;
      if ((act & it.mask) !== (it.exp & it.mask)) begin
        bad++;
        $display("FAIL %s actual=%b expected=%b mask=%b", it.tag, act, it.exp, it.mask);
      end
    end
  end

  initial begin
    tick(2);
    chk("R9 reset values", 5'b00011, 5'b11111);
    rst_n = 1;
    tick(1);
    chk("R3 lock absent sets flag", 5'b00100, 5'b00100);
    sd = 1; lk = 1;
    tick(1);
    chk("R1 one edge not enough", 5'b00010, 5'b00010);
    tick(1);
    chk("R1 R3 err clear, flag latched", 5'b00100, 5'b00110);
    sd = 0;
    tick(1);
    sd = 1;
    tick(G + 1);
    chk("R6 count restarted", 5'b00001, 5'b01001);
    tick(1);
    chk("R5 R7 R8 link up std still low", 5'b01000, 5'b11011);
    rd_qp = 1;
    tick(1);
    chk("R4 read with lock clears", 5'b00000, 5'b00100);
    rd_qp = 0; rd_std = 1;
    tick(1);
    chk("R8 read while good sets", 5'b10000, 5'b10000);
    rd_std = 0;
    tick(3);
    chk("R8 std holds", 5'b11000, 5'b11111);
    lk = 0; rd_qp = 1;
    tick(2);
    chk("R2 lock loss channel error", 5'b11010, 5'b11010);
    rd_std = 1;
    tick(1);
    chk("R8 R4 R5 fault same cycle as reads", 5'b00111, 5'b11111);
    rd_std = 0;
    tick(2);
    chk("R4 read without lock keeps flag", 5'b00100, 5'b00100);
    lk = 1; rd_qp = 0;
    tick(G + 4);
    chk("R3 R7 R8 relock: flag kept, std low", 5'b01100, 5'b11111);
    rd_qp = 1;
    tick(1);
    chk("R4 cleared after relock", 5'b00000, 5'b00100);
    rd_qp = 0;
    sd = 0;
    tick(2);
    chk("R2 signal loss alone", 5'b00010, 5'b00110);
    tick(1);
    chk("R5 R7 fault on signal loss", 5'b00001, 5'b01001);
    tick(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule